// File: doc/BRIEF.md
# Command-Coded Register Port

This block is the slave side of a 16-bit parallel host bus on a peripheral controller whose registers have no direct address decode. The host selects a register by writing a command byte, then moves data in separate data-phase bus cycles. A single address line picks the cycle type: with it high, a write cycle carries a command code. With it low, a read or write cycle carries one data word for the register named by the last command.

Each register has its own read code and write code. The two codes differ only in bit 7, which marks a write. A register wider than one bus word is moved over several data phases, least significant word first. An internal word index is cleared by every command phase and steps once per accepted data phase. Commands that take no data fire an action pulse as soon as their code is written. Codes that match nothing raise a one-cycle error pulse.

Three registers are built in: one word with only its low byte defined, two words, and three words. All bus outputs are registered. They change on the clock edge that samples the strobe.

Top module: `cmdport_regif`

## Requirements
- R1: After reset, bus_rdata, act_pulse, act_code and bad_cmd are zero and every register reads back as zero.
- R2: A write cycle with bus_a0 high is a command phase; only bus_wdata[7:0] forms the code and bus_wdata[15:8] has no effect.
- R3: Register n (n = 0, 1, 2) is selected for reading by code 0x10+n and for writing by code 0x90+n; bit 7 of the code set means write. Register n holds n+1 words.
- R4: The word index is zero after each command phase and advances by one per accepted data phase, so words move least significant first.
- R5: Data phases past the last word of the selected register store nothing and read as zero.
- R6: Codes 0x40 and 0x41 take no data: act_pulse is high for exactly the one cycle after the command strobe with act_code equal to the code, and afterwards no register is selected.
- R7: Any other code (including 0x13, 0xC0, 0xC1) raises bad_cmd for one cycle, moves no data and leaves no register selected.
- R8: A data phase with no register selected is ignored on write and loads zero into bus_rdata on read.
- R9: An access whose bus_lanes is not 2'b11, or that has both strobes high, has no effect at all: no command, no store, no index step, bus_rdata held.
- R10: Register 0 defines only bits 7:0; its bits 15:8 read as zero and are dropped on write.
- R11: A data phase whose direction opposes the latched code (write strobe under a read code, or the reverse) stores nothing, does not step the index, and on read loads zero.
- R12: bus_rdata is loaded only on the clock edge that samples a read strobe with bus_a0 low, and holds otherwise (a read strobe with bus_a0 high is ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_a0 | input | 1 | Cycle type: 1 command, 0 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_lanes | input | 2 | Byte lane enables; only 2'b11 is a legal access |
| bus_wdata | input | 16 | Write data / command code in bits 7:0 |
| bus_rdata | output | 16 | Registered read data |
| act_pulse | output | 1 | One-cycle pulse for a no-data command |
| act_code | output | 8 | Code of the last no-data command |
| bad_cmd | output | 1 | One-cycle pulse for an unknown code |

## Verification
The assertions assume the host raises each strobe for a single cycle per access and that inputs are stable around the sampling edge. They also assume that the reset input may drop at any time, with all checks suspended until the internal release. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle. It inserts partial-lane and double-strobe accesses only as deliberate illegal cases, whose absence of effect is then observed through later reads.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;
  localparam int DATA_W    = 16;
  localparam int CODE_W    = 8;
  localparam int NUM_REG   = 3;
  localparam int MAX_WORDS = 3;
  localparam int NUM_ACT   = 2;
  localparam int REG_IDX_W = $clog2(NUM_REG);
  localparam int WIDX_W    = $clog2(MAX_WORDS + 1);

  localparam logic [6:0] REG_BASE = 7'h10;
  localparam logic [6:0] REG_END  = 7'(int'(REG_BASE) + NUM_REG);
  localparam logic [6:0] ACT_BASE = 7'h40;
  localparam logic [6:0] ACT_END  = 7'(int'(ACT_BASE) + NUM_ACT);

  typedef enum logic [1:0] {
    CK_REG_RD  = 2'd0,
    CK_REG_WR  = 2'd1,
    CK_ACTION  = 2'd2,
    CK_UNKNOWN = 2'd3
  } cmd_kind_e;

  // Words per register: register n spans n+1 bus words.
  function automatic int reg_words(int idx);
    return idx + 1;
  endfunction

  // Defined bits of each word; register 0 only owns its low byte.
  function automatic logic [DATA_W-1:0] reg_mask(int idx);
    if (idx == 0) return DATA_W'(16'h00FF);
    return '1;
  endfunction
endpackage

// File: rtl/cmdif_decode.sv
module cmdif_decode
  import cmdif_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int RW = REG_IDX_W
) (
  input  logic [CW-1:0] code,
  output cmd_kind_e     kind,
  output logic [RW-1:0] reg_sel
);
  logic [6:0] low;

  always_comb begin
    low     = code[6:0];
    kind    = CK_UNKNOWN;
    reg_sel = '0;
    if (low >= REG_BASE && low < REG_END) begin
      kind    = code[CW-1] ? CK_REG_WR : CK_REG_RD;
      reg_sel = RW'(low - REG_BASE);
    end else if (!code[CW-1] && low >= ACT_BASE && low < ACT_END) begin
      kind = CK_ACTION;
    end
  end
endmodule

// File: rtl/cmdif_seq.sv
module cmdif_seq
  import cmdif_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int RW = REG_IDX_W,
  parameter int IW = WIDX_W,
  parameter int MW = MAX_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_ok,
  input  logic          a0,
  input  logic          wr,
  input  logic          rd,
  input  logic [CW-1:0] code,
  input  cmd_kind_e     kind,
  input  logic [RW-1:0] reg_sel,
  output logic [RW-1:0] cur_reg,
  output logic [IW-1:0] word_idx,
  output logic          we,
  output logic          rd_load,
  output logic          rd_hit,
  output logic          exec_pulse,
  output logic [CW-1:0] exec_code,
  output logic          err_pulse
);
  logic          valid_q, valid_d;
  logic          dirwr_q, dirwr_d;
  logic [RW-1:0] reg_q, reg_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          exec_d, err_d;
  logic [CW-1:0] code_d;
  logic          cmd_stb, dat_wr, dat_rd, match, in_range;

  always_comb begin
    cmd_stb  = acc_ok && wr && a0;
    dat_wr   = acc_ok && wr && !a0;
    dat_rd   = acc_ok && rd && !a0;
    match    = valid_q && ((dat_wr && dirwr_q) || (dat_rd && !dirwr_q));
    in_range = int'(idx_q) < reg_words(int'(reg_q));
    we       = match && dat_wr && in_range;
    rd_hit   = match && dat_rd && in_range;
    rd_load  = dat_rd;
  end

  always_comb begin
    valid_d = valid_q;
    dirwr_d = dirwr_q;
    reg_d   = reg_q;
    idx_d   = idx_q;
    if (cmd_stb) begin
      idx_d   = '0;
      valid_d = (kind == CK_REG_RD) || (kind == CK_REG_WR);
      dirwr_d = (kind == CK_REG_WR);
      reg_d   = reg_sel;
    end else if (match && int'(idx_q) < MW) begin
      idx_d = idx_q + IW'(1);
    end
    exec_d = cmd_stb && (kind == CK_ACTION);
    err_d  = cmd_stb && (kind == CK_UNKNOWN);
    code_d = exec_d ? code : exec_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      dirwr_q    <= 1'b0;
      reg_q      <= '0;
      idx_q      <= '0;
      exec_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      exec_code  <= '0;
    end else begin
      valid_q    <= valid_d;
      dirwr_q    <= dirwr_d;
      reg_q      <= reg_d;
      idx_q      <= idx_d;
      exec_pulse <= exec_d;
      err_pulse  <= err_d;
      exec_code  <= code_d;
    end
  end

  assign cur_reg  = reg_q;
  assign word_idx = idx_q;

  // R4: every command phase restarts the word count
  a_r4_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && wr && a0) |=> (word_idx == '0));
  // R7: an error pulse only follows a command write
  a_r7_err_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(wr && a0));
  // R6: an action pulse only follows a command write, never with an error
  a_r6_exec_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> ($past(wr && a0) && !err_pulse));
endmodule

// File: rtl/cmdif_regfile.sv
module cmdif_regfile
  import cmdif_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NUM_REG,
  parameter int MW = MAX_WORDS,
  parameter int RW = REG_IDX_W,
  parameter int IW = WIDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] sel,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rword
);
  logic [DW-1:0] words [NR][MW];

  for (genvar gi = 0; gi < NR; gi++) begin : g_reg
    for (genvar gw = 0; gw < MW; gw++) begin : g_word
      if (gw < reg_words(gi)) begin : g_store
        logic          en;
        logic [DW-1:0] q;
        assign en = we && (sel == RW'(gi)) && (widx == IW'(gw));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  q <= '0;
          else if (en) q <= wdata & DW'(reg_mask(gi));
        end
        assign words[gi][gw] = q;
      end else begin : g_absent
        assign words[gi][gw] = '0;
      end
    end
  end

  always_comb begin
    rword = '0;
    if (int'(sel) < NR && int'(widx) < MW) rword = words[sel][widx];
  end

  // R5: the sequencer never stores past the selected register's width
  a_r5_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(widx) < reg_words(int'(sel))));
endmodule

// File: rtl/cmdport_regif.sv
module cmdport_regif
  import cmdif_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_a0,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_lanes,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          act_pulse,
  output logic [CW-1:0] act_code,
  output logic          bad_cmd
);
  logic [1:0]           rst_sync;
  logic                 rst_s;
  logic                 acc_ok;
  cmd_kind_e            kind;
  logic [REG_IDX_W-1:0] dec_reg, cur_reg;
  logic [WIDX_W-1:0]    word_idx;
  logic                 we, rd_load, rd_hit;
  logic [DW-1:0]        rword, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign acc_ok = (bus_lanes == 2'b11) && (bus_wr ^ bus_rd);

  cmdif_decode #(.CW(CW), .RW(REG_IDX_W)) u_dec (
    .code    (bus_wdata[CW-1:0]),
    .kind    (kind),
    .reg_sel (dec_reg)
  );

  cmdif_seq #(.CW(CW), .RW(REG_IDX_W), .IW(WIDX_W), .MW(MAX_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s),
    .acc_ok     (acc_ok),
    .a0         (bus_a0),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .code       (bus_wdata[CW-1:0]),
    .kind       (kind),
    .reg_sel    (dec_reg),
    .cur_reg    (cur_reg),
    .word_idx   (word_idx),
    .we         (we),
    .rd_load    (rd_load),
    .rd_hit     (rd_hit),
    .exec_pulse (act_pulse),
    .exec_code  (act_code),
    .err_pulse  (bad_cmd)
  );

  cmdif_regfile #(.DW(DW), .NR(NUM_REG), .MW(MAX_WORDS), .RW(REG_IDX_W), .IW(WIDX_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_s),
    .we    (we),
    .sel   (cur_reg),
    .widx  (word_idx),
    .wdata (bus_wdata),
    .rword (rword)
  );

  always_comb begin
    rdata_d = bus_rdata;
    if (rd_load) rdata_d = rd_hit ? rword : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) bus_rdata <= '0;
    else        bus_rdata <= rdata_d;
  end

  // R12: read data moves only on an edge that samples a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_rd |=> $stable(bus_rdata));
  // R9: an access with partial lanes raises no pulse
  a_r9_partial_silent: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_lanes != 2'b11) |=> (!act_pulse && !bad_cmd));
endmodule

// File: tb/cmdport_regif_test.sv
module cmdport_regif_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_a0, bus_wr, bus_rd;
  logic [1:0]  bus_lanes;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        act_pulse, bad_cmd;
  logic [7:0]  act_code;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdport_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_lanes(bus_lanes), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .act_pulse(act_pulse), .act_code(act_code), .bad_cmd(bad_cmd)
  );

  typedef struct packed {
    logic        a0;
    logic        wr;
    logic        rd;
    logic [1:0]  ln;
    logic [15:0] din;
    logic [15:0] erd;
    logic        ex;
    logic        er;
    logic [7:0]  code;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b1,1'b0,2'd3,16'hAB91,16'h0000,1'b0,1'b0,8'h00,8'd2},  // R2 upper byte ignored, write reg1
    '{1'b0,1'b1,1'b0,2'd3,16'h1111,16'h0000,1'b0,1'b0,8'h00,8'd4},  // R4 word 0
    '{1'b0,1'b1,1'b0,2'd3,16'h2222,16'h0000,1'b0,1'b0,8'h00,8'd4},  // R4 word 1
    '{1'b0,1'b1,1'b0,2'd3,16'h3333,16'h0000,1'b0,1'b0,8'h00,8'd5},  // R5 past width
    '{1'b1,1'b1,1'b0,2'd3,16'h0011,16'h0000,1'b0,1'b0,8'h00,8'd3},  // R3 read reg1
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h1111,1'b0,1'b0,8'h00,8'd4},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h2222,1'b0,1'b0,8'h00,8'd4},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h0000,1'b0,1'b0,8'h00,8'd5},  // R5 reads zero
    '{1'b1,1'b1,1'b0,2'd3,16'h0090,16'h0000,1'b0,1'b0,8'h00,8'd3},  // R3 write reg0
    '{1'b0,1'b1,1'b0,2'd3,16'hBEEF,16'h0000,1'b0,1'b0,8'h00,8'd10}, // R10
    '{1'b1,1'b1,1'b0,2'd3,16'h0010,16'h0000,1'b0,1'b0,8'h00,8'd3},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h00EF,1'b0,1'b0,8'h00,8'd10}, // R10 high byte dropped
    '{1'b1,1'b1,1'b0,2'd3,16'h0092,16'h00EF,1'b0,1'b0,8'h00,8'd3},  // write reg2
    '{1'b0,1'b1,1'b0,2'd3,16'hA001,16'h00EF,1'b0,1'b0,8'h00,8'd4},
    '{1'b0,1'b1,1'b0,2'd3,16'hA002,16'h00EF,1'b0,1'b0,8'h00,8'd4},
    '{1'b0,1'b1,1'b0,2'd3,16'hA003,16'h00EF,1'b0,1'b0,8'h00,8'd4},
    '{1'b1,1'b1,1'b0,2'd3,16'h0012,16'h00EF,1'b0,1'b0,8'h00,8'd3},
    '{1'b0,1'b1,1'b0,2'd3,16'h7777,16'h00EF,1'b0,1'b0,8'h00,8'd11}, // R11 write under read code
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'hA001,1'b0,1'b0,8'h00,8'd11}, // R11 no index step
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'hA002,1'b0,1'b0,8'h00,8'd4},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'hA003,1'b0,1'b0,8'h00,8'd4},
    '{1'b1,1'b1,1'b0,2'd3,16'h0091,16'hA003,1'b0,1'b0,8'h00,8'd3},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h0000,1'b0,1'b0,8'h00,8'd11}, // R11 read under write code
    '{1'b0,1'b1,1'b0,2'd3,16'h4444,16'h0000,1'b0,1'b0,8'h00,8'd11}, // lands in word 0
    '{1'b1,1'b1,1'b0,2'd3,16'h0011,16'h0000,1'b0,1'b0,8'h00,8'd3},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h4444,1'b0,1'b0,8'h00,8'd11},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h2222,1'b0,1'b0,8'h00,8'd4},
    '{1'b1,1'b1,1'b0,2'd3,16'h0041,16'h2222,1'b1,1'b0,8'h41,8'd6},  // R6 action 0x41
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h0000,1'b0,1'b0,8'h00,8'd8},  // R8 read, none selected
    '{1'b0,1'b1,1'b0,2'd3,16'h5A5A,16'h0000,1'b0,1'b0,8'h00,8'd8},  // R8 write ignored
    '{1'b1,1'b1,1'b0,2'd3,16'h00C0,16'h0000,1'b0,1'b1,8'h00,8'd7},  // R7 unknown
    '{1'b0,1'b1,1'b0,2'd3,16'h9999,16'h0000,1'b0,1'b0,8'h00,8'd7},
    '{1'b1,1'b1,1'b0,2'd3,16'h0011,16'h0000,1'b0,1'b0,8'h00,8'd7},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h4444,1'b0,1'b0,8'h00,8'd7},  // R7 no data moved
    '{1'b1,1'b1,1'b0,2'd3,16'h0040,16'h4444,1'b1,1'b0,8'h40,8'd6},  // R6 action 0x40
    '{1'b1,1'b1,1'b0,2'd3,16'h0011,16'h4444,1'b0,1'b0,8'h00,8'd3},
    '{1'b1,1'b1,1'b0,2'd1,16'h0091,16'h4444,1'b0,1'b0,8'h00,8'd9},  // R9 partial command
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h4444,1'b0,1'b0,8'h00,8'd9},  // read code kept
    '{1'b0,1'b0,1'b1,2'd2,16'h0000,16'h4444,1'b0,1'b0,8'h00,8'd9},  // R9 partial read
    '{1'b0,1'b1,1'b1,2'd3,16'h0000,16'h4444,1'b0,1'b0,8'h00,8'd9},  // R9 both strobes
    '{1'b1,1'b0,1'b1,2'd3,16'h0000,16'h4444,1'b0,1'b0,8'h00,8'd12}, // R12 read with a0 high
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h2222,1'b0,1'b0,8'h00,8'd9},  // index did not step
    '{1'b1,1'b1,1'b0,2'd3,16'h0091,16'h2222,1'b0,1'b0,8'h00,8'd3},
    '{1'b0,1'b1,1'b0,2'd2,16'h8888,16'h2222,1'b0,1'b0,8'h00,8'd9},  // R9 partial write
    '{1'b0,1'b1,1'b0,2'd3,16'h6666,16'h2222,1'b0,1'b0,8'h00,8'd9},
    '{1'b1,1'b1,1'b0,2'd3,16'h0011,16'h2222,1'b0,1'b0,8'h00,8'd3},
    '{1'b0,1'b0,1'b1,2'd3,16'h0000,16'h6666,1'b0,1'b0,8'h00,8'd9},
    '{1'b1,1'b1,1'b0,2'd3,16'h0013,16'h6666,1'b0,1'b1,8'h00,8'd7},  // R7 code 0x13
    '{1'b1,1'b1,1'b0,2'd3,16'h00C1,16'h6666,1'b0,1'b1,8'h00,8'd7}   // R7 code 0xC1
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_a0 = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_lanes = 2'b11; bus_wdata = '0;
  endtask

  task automatic access(input logic a0, input logic wr, input logic rd, input logic [15:0] d);
    bus_a0 = a0; bus_wr = wr; bus_rd = rd; bus_lanes = 2'b11; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "rdata", bus_rdata, 16'h0000);
    check("R1", "act_pulse", 16'(act_pulse), 16'h0);
    check("R1", "bad_cmd", 16'(bad_cmd), 16'h0);
    check("R1", "act_code", 16'(act_code), 16'h0);

    for (int i = 0; i < NV; i++) begin
      bus_a0 = VT[i].a0; bus_wr = VT[i].wr; bus_rd = VT[i].rd;
      bus_lanes = VT[i].ln; bus_wdata = VT[i].din;
      @(negedge clk);
      idle();
      check($sformatf("R%0d vec%0d", VT[i].req, i), "rdata", bus_rdata, VT[i].erd);
      check($sformatf("R%0d vec%0d", VT[i].req, i), "act_pulse", 16'(act_pulse), 16'(VT[i].ex));
      check($sformatf("R%0d vec%0d", VT[i].req, i), "bad_cmd", 16'(bad_cmd), 16'(VT[i].er));
      if (VT[i].ex) check($sformatf("R%0d vec%0d", VT[i].req, i), "act_code", 16'(act_code), 16'(VT[i].code));
    end

    // R6 pulse lasts one cycle, code held
    access(1'b1, 1'b1, 1'b0, 16'h0041);
    check("R6", "act_pulse first", 16'(act_pulse), 16'h1);
    @(negedge clk);
    check("R6", "act_pulse second", 16'(act_pulse), 16'h0);
    check("R6", "act_code held", 16'(act_code), 16'h0041);

    // R7 pulse lasts one cycle
    access(1'b1, 1'b1, 1'b0, 16'h0055);
    check("R7", "bad_cmd first", 16'(bad_cmd), 16'h1);
    @(negedge clk);
    check("R7", "bad_cmd second", 16'(bad_cmd), 16'h0);

    // R1 reset mid-run clears registers and outputs
    access(1'b1, 1'b1, 1'b0, 16'h0011);
    access(1'b0, 1'b0, 1'b1, 16'h0000);
    check("R1", "pre-reset read", bus_rdata, 16'h6666);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "rdata in reset", bus_rdata, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "act_code after reset", 16'(act_code), 16'h0000);
    access(1'b1, 1'b1, 1'b0, 16'h0011);
    access(1'b0, 1'b0, 1'b1, 16'h0000);
    access(1'b0, 1'b0, 1'b1, 16'h0000);
    check("R1", "reg1 word1 cleared", bus_rdata, 16'h0000);
    access(1'b1, 1'b1, 1'b0, 16'h0012);
    access(1'b0, 1'b0, 1'b1, 16'h0000);
    check("R1", "reg2 word0 cleared", bus_rdata, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule